// File: doc/BRIEF.md
# Byte-Lane Synchronous Dual-Port Memory

This block is a memory with two ports that can each read or write any word in the same clock cycle, including the same word. Both ports run on one shared clock. Each port takes a request on the rising edge: an address, write data, a read/write strobe, a pair of enables of opposite polarity and one active-low select per byte lane. The block registers that request. On the next edge the write reaches the array, or the read data becomes visible.

Read data leaves each port on a plain 16-bit bus with one drive flag per byte lane, not on tri-state pins. A lane whose flag is low reads as zero. A static per-port input picks the read latency. In flow-through mode the data shows in the cycle after the request is registered. In registered mode an output register adds one more cycle, and the drive flags pass through it with the data. An active-low output enable gates the flags with no clock involved. The depth is 2**ADDR_W words; ADDR_W = 16 gives the full 65536-word array.

Top module: `tdp_byte_ram`

## Requirements
- R1: Both ports can access any word in the same cycle, each independently of the other, and the array holds 2**ADDR_W words of DATA_W bits.
- R2: A port whose active-low enable is high or whose active-high enable is low when sampled on the rising edge writes nothing and drives no lane in the resulting output cycle.
- R3: A selected port with both lane selects high accesses no byte: nothing is written and both drive flags stay low.
- R4: With the read strobe low (write), only the lanes whose select is low are written: select bit 1 governs bits 15:8 and select bit 0 governs bits 7:0. A write drives no lane.
- R5: With the read strobe high and the output enable low, drive flag i is high exactly for each lane whose select bit i was low. An undriven lane of read data is zero.
- R6: The output enable acts with no clock. While it is high, both drive flags are low and the read data is zero, whatever the registered state.
- R7: In flow-through mode (latency input 0), read data for a request registered at edge N is valid between edge N and edge N+1.
- R8: In registered mode (latency input 1), the read data and its drive flags appear one edge later: between edge N+1 and edge N+2.
- R9: When both ports write the same word on the same edge, port A's data wins on every lane that both ports select. A lane selected by only one port takes that port's data.
- R10: A read registered on the same edge as a write to the same word on the other port returns the old contents. A read registered on the following edge returns the new contents.
- R11: While the active-low synchronous reset is held, the input and output registers clear, so both drive flags read low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock; rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| a_en_n | input | 1 | Port A enable, active low |
| a_en | input | 1 | Port A enable, active high |
| a_rd | input | 1 | Port A strobe: 1 read, 0 write |
| a_lane_n | input | NLANES | Port A lane selects, active low; bit 1 upper byte |
| a_oe_n | input | 1 | Port A output enable, active low, acts without clock |
| a_reg_out | input | 1 | Port A latency: 0 flow-through, 1 registered |
| a_addr | input | ADDR_W | Port A word address |
| a_wdata | input | DATA_W | Port A write data |
| a_rdata | output | DATA_W | Port A read data, undriven lanes zero |
| a_drive | output | NLANES | Port A per-lane drive flags |
| b_en_n | input | 1 | Port B enable, active low |
| b_en | input | 1 | Port B enable, active high |
| b_rd | input | 1 | Port B strobe: 1 read, 0 write |
| b_lane_n | input | NLANES | Port B lane selects, active low; bit 1 upper byte |
| b_oe_n | input | 1 | Port B output enable, active low, acts without clock |
| b_reg_out | input | 1 | Port B latency: 0 flow-through, 1 registered |
| b_addr | input | ADDR_W | Port B word address |
| b_wdata | input | DATA_W | Port B write data |
| b_rdata | output | DATA_W | Port B read data, undriven lanes zero |
| b_drive | output | NLANES | Port B per-lane drive flags |

## Verification
The latency properties assume that a port's latency input holds steady over the cycles a property spans. This matches its role as a static strapping. The bench changes that input only while the port is idle, with no read in flight. The properties also assume the inputs are settled at each rising edge. The bench meets this by changing every input on the falling edge and sampling outputs on the next falling edge, away from the edge where registers load. The output enable is the one exception: the bench toggles it between edges on purpose, to show that it acts with no clock.

// File: rtl/tdp_pkg.sv
package tdp_pkg;

   typedef enum logic {
      LAT_FLOW = 1'b0,
      LAT_REG  = 1'b1
   } lat_mode_e;

   // port takes part in a cycle only with both enables at their active level
   function automatic logic port_live(input logic en_n, input logic en);
      return (~en_n) & en;
   endfunction

endpackage

// File: rtl/tdp_in_stage.sv
module tdp_in_stage #(
   parameter int ADDR_W = 11,
   parameter int DATA_W = 16,
   parameter int NLANES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en_n,
   input  logic              en,
   input  logic              rd,
   input  logic [NLANES-1:0] lane_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [ADDR_W-1:0] q_addr,
   output logic [DATA_W-1:0] q_wdata,
   output logic [NLANES-1:0] q_wr,
   output logic [NLANES-1:0] q_rdl
);
   import tdp_pkg::*;

   logic              live;
   logic [NLANES-1:0] wr_d;
   logic [NLANES-1:0] rd_d;

   assign live = port_live(en_n, en);

   for (genvar l = 0; l < NLANES; l++) begin : g_lane
      assign wr_d[l] = live & ~rd & ~lane_n[l];
      assign rd_d[l] = live &  rd & ~lane_n[l];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         q_addr  <= '0;
         q_wdata <= '0;
         q_wr    <= '0;
         q_rdl   <= '0;
      end else begin
         q_addr  <= addr;
         q_wdata <= wdata;
         q_wr    <= wr_d;
         q_rdl   <= rd_d;
      end
   end

endmodule

// File: rtl/tdp_array.sv
module tdp_array #(
   parameter int ADDR_W = 11,
   parameter int DATA_W = 16,
   parameter int LANE_W = 8,
   parameter int NLANES = 2
) (
   input  logic              clk,
   input  logic [ADDR_W-1:0] a_addr,
   input  logic [DATA_W-1:0] a_wdata,
   input  logic [NLANES-1:0] a_wr,
   input  logic [ADDR_W-1:0] b_addr,
   input  logic [DATA_W-1:0] b_wdata,
   input  logic [NLANES-1:0] b_wr,
   output logic [DATA_W-1:0] a_rdata,
   output logic [DATA_W-1:0] b_rdata
);
   localparam int DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] mem [DEPTH];

   // port B lanes are scheduled first so that port A overrides them on a clash
   always_ff @(posedge clk) begin
      for (int l = 0; l < NLANES; l++) begin
         if (b_wr[l]) mem[b_addr][l*LANE_W +: LANE_W] <= b_wdata[l*LANE_W +: LANE_W];
         if (a_wr[l]) mem[a_addr][l*LANE_W +: LANE_W] <= a_wdata[l*LANE_W +: LANE_W];
      end
   end

   // reads see the array before this edge's writes land
   assign a_rdata = mem[a_addr];
   assign b_rdata = mem[b_addr];

endmodule

// File: rtl/tdp_out_stage.sv
module tdp_out_stage #(
   parameter int  DATA_W   = 16,
   parameter int  LANE_W   = 8,
   parameter int  NLANES   = 2,
   parameter bit  HAS_REG  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_out,
   input  logic              oe_n,
   input  logic [DATA_W-1:0] flow_data,
   input  logic [NLANES-1:0] flow_lane,
   output logic [DATA_W-1:0] rdata,
   output logic [NLANES-1:0] drive
);
   import tdp_pkg::*;

   logic [DATA_W-1:0] sel_data;
   logic [NLANES-1:0] sel_lane;

   if (HAS_REG) begin : g_reg
      logic [DATA_W-1:0] hold_data;
      logic [NLANES-1:0] hold_lane;
      lat_mode_e         mode;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            hold_data <= '0;
            hold_lane <= '0;
         end else begin
            hold_data <= flow_data;
            hold_lane <= flow_lane;
         end
      end

      assign mode = lat_mode_e'(reg_out);

      always_comb begin
         case (mode)
            LAT_REG: begin
               sel_data = hold_data;
               sel_lane = hold_lane;
            end
            default: begin
               sel_data = flow_data;
               sel_lane = flow_lane;
            end
         endcase
      end
   end else begin : g_flow
      logic unused_mode;
      assign unused_mode = reg_out;
      assign sel_data    = flow_data;
      assign sel_lane    = flow_lane;
   end

   for (genvar l = 0; l < NLANES; l++) begin : g_lane
      assign drive[l] = sel_lane[l] & ~oe_n;
      assign rdata[l*LANE_W +: LANE_W] = drive[l] ? sel_data[l*LANE_W +: LANE_W] : '0;
   end

endmodule

// File: rtl/tdp_byte_ram.sv
module tdp_byte_ram #(
   parameter int ADDR_W  = 11,
   parameter int DATA_W  = 16,
   parameter int LANE_W  = 8,
   parameter bit HAS_REG = 1'b1,
   localparam int NLANES = DATA_W / LANE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              a_en_n,
   input  logic              a_en,
   input  logic              a_rd,
   input  logic [NLANES-1:0] a_lane_n,
   input  logic              a_oe_n,
   input  logic              a_reg_out,
   input  logic [ADDR_W-1:0] a_addr,
   input  logic [DATA_W-1:0] a_wdata,
   output logic [DATA_W-1:0] a_rdata,
   output logic [NLANES-1:0] a_drive,
   input  logic              b_en_n,
   input  logic              b_en,
   input  logic              b_rd,
   input  logic [NLANES-1:0] b_lane_n,
   input  logic              b_oe_n,
   input  logic              b_reg_out,
   input  logic [ADDR_W-1:0] b_addr,
   input  logic [DATA_W-1:0] b_wdata,
   output logic [DATA_W-1:0] b_rdata,
   output logic [NLANES-1:0] b_drive
);
   localparam int NPORTS = 2;

   if (DATA_W % LANE_W != 0) begin : g_bad_lane
      $error("DATA_W must be a whole number of lanes");
   end
   if (ADDR_W < 1 || ADDR_W > 16) begin : g_bad_addr
      $error("ADDR_W must lie in 1..16");
   end

   logic              p_en_n   [NPORTS];
   logic              p_en     [NPORTS];
   logic              p_rd     [NPORTS];
   logic [NLANES-1:0] p_lane_n [NPORTS];
   logic              p_oe_n   [NPORTS];
   logic              p_reg    [NPORTS];
   logic [ADDR_W-1:0] p_addr   [NPORTS];
   logic [DATA_W-1:0] p_wdata  [NPORTS];
   logic [DATA_W-1:0] p_rdata  [NPORTS];
   logic [NLANES-1:0] p_drive  [NPORTS];

   assign p_en_n[0] = a_en_n;     assign p_en_n[1] = b_en_n;
   assign p_en[0]   = a_en;       assign p_en[1]   = b_en;
   assign p_rd[0]   = a_rd;       assign p_rd[1]   = b_rd;
   assign p_lane_n[0] = a_lane_n; assign p_lane_n[1] = b_lane_n;
   assign p_oe_n[0] = a_oe_n;     assign p_oe_n[1] = b_oe_n;
   assign p_reg[0]  = a_reg_out;  assign p_reg[1]  = b_reg_out;
   assign p_addr[0] = a_addr;     assign p_addr[1] = b_addr;
   assign p_wdata[0] = a_wdata;   assign p_wdata[1] = b_wdata;

   assign a_rdata = p_rdata[0];   assign b_rdata = p_rdata[1];
   assign a_drive = p_drive[0];   assign b_drive = p_drive[1];

   logic [ADDR_W-1:0] q_addr  [NPORTS];
   logic [DATA_W-1:0] q_wdata [NPORTS];
   logic [NLANES-1:0] q_wr    [NPORTS];
   logic [NLANES-1:0] q_rdl   [NPORTS];
   logic [DATA_W-1:0] arr_rd  [NPORTS];

   for (genvar gp = 0; gp < NPORTS; gp++) begin : g_port
      tdp_in_stage #(
         .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NLANES(NLANES)
      ) u_in (
         .clk    (clk),
         .rst_n  (rst_n),
         .en_n   (p_en_n[gp]),
         .en     (p_en[gp]),
         .rd     (p_rd[gp]),
         .lane_n (p_lane_n[gp]),
         .addr   (p_addr[gp]),
         .wdata  (p_wdata[gp]),
         .q_addr (q_addr[gp]),
         .q_wdata(q_wdata[gp]),
         .q_wr   (q_wr[gp]),
         .q_rdl  (q_rdl[gp])
      );

      tdp_out_stage #(
         .DATA_W(DATA_W), .LANE_W(LANE_W), .NLANES(NLANES), .HAS_REG(HAS_REG)
      ) u_out (
         .clk      (clk),
         .rst_n    (rst_n),
         .reg_out  (p_reg[gp]),
         .oe_n     (p_oe_n[gp]),
         .flow_data(arr_rd[gp]),
         .flow_lane(q_rdl[gp]),
         .rdata    (p_rdata[gp]),
         .drive    (p_drive[gp])
      );
   end

   tdp_array #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANE_W(LANE_W), .NLANES(NLANES)
   ) u_array (
      .clk    (clk),
      .a_addr (q_addr[0]),
      .a_wdata(q_wdata[0]),
      .a_wr   (q_wr[0]),
      .b_addr (q_addr[1]),
      .b_wdata(q_wdata[1]),
      .b_wr   (q_wr[1]),
      .a_rdata(arr_rd[0]),
      .b_rdata(arr_rd[1])
   );

endmodule

// File: rtl/tdp_port_chk.sv
module tdp_port_chk #(
   parameter int DATA_W = 16,
   parameter int LANE_W = 8,
   parameter int NLANES = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              en_n,
   input logic              en,
   input logic              rd,
   input logic [NLANES-1:0] lane_n,
   input logic              oe_n,
   input logic              reg_out,
   input logic [DATA_W-1:0] rdata,
   input logic [NLANES-1:0] drive
);

   // R6: output enable high silences the port
   assert_oe_silence_R6: assert property (@(posedge clk) disable iff (!rst_n)
      oe_n |-> (drive == '0 && rdata == '0));

   // R2: deselected request yields no drive in flow-through mode
   assert_deselect_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!reg_out && (en_n || !en)) ##1 !reg_out |-> drive == '0);

   // R3: no lane selected yields no drive
   assert_nolane_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!reg_out && lane_n == '1) ##1 !reg_out |-> drive == '0);

   // R4: a write never drives
   assert_write_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!reg_out && !rd) ##1 !reg_out |-> drive == '0);

   // R7: full-width flow-through read drives every lane one cycle on
   assert_flow_drive_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!reg_out && rd && !en_n && en && lane_n == '0) ##1 (!reg_out && !oe_n)
      |-> drive == '1);

   // R8: registered read drives every lane two cycles on
   assert_reg_drive_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_out && rd && !en_n && en && lane_n == '0) ##1 reg_out ##1 (reg_out && !oe_n)
      |-> drive == '1);

   // R5: undriven lane reads as zero
   for (genvar l = 0; l < NLANES; l++) begin : g_lane
      assert_undriven_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
         !drive[l] |-> rdata[l*LANE_W +: LANE_W] == '0);
   end

endmodule

bind tdp_byte_ram tdp_port_chk #(
   .DATA_W(DATA_W), .LANE_W(LANE_W), .NLANES(NLANES)
) u_chk_a (
   .clk(clk), .rst_n(rst_n), .en_n(a_en_n), .en(a_en), .rd(a_rd),
   .lane_n(a_lane_n), .oe_n(a_oe_n), .reg_out(a_reg_out),
   .rdata(a_rdata), .drive(a_drive)
);

bind tdp_byte_ram tdp_port_chk #(
   .DATA_W(DATA_W), .LANE_W(LANE_W), .NLANES(NLANES)
) u_chk_b (
   .clk(clk), .rst_n(rst_n), .en_n(b_en_n), .en(b_en), .rd(b_rd),
   .lane_n(b_lane_n), .oe_n(b_oe_n), .reg_out(b_reg_out),
   .rdata(b_rdata), .drive(b_drive)
);

// File: tb/test_tdp_byte_ram.sv
module test_tdp_byte_ram;
   localparam int AW    = 6;
   localparam int WORDS = 1 << AW;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = ~clk;

   logic          en_n  [2];
   logic          en    [2];
   logic          rd    [2];
   logic [1:0]    ln_n  [2];
   logic          oe_n  [2];
   logic          rgo   [2];
   logic [AW-1:0] addr  [2];
   logic [15:0]   wd    [2];
   logic [15:0]   rdata [2];
   logic [1:0]    drive [2];

   tdp_byte_ram #(.ADDR_W(AW)) i_tdp_byte_ram (
      .clk(clk), .rst_n(rst_n),
      .a_en_n(en_n[0]), .a_en(en[0]), .a_rd(rd[0]), .a_lane_n(ln_n[0]),
      .a_oe_n(oe_n[0]), .a_reg_out(rgo[0]), .a_addr(addr[0]), .a_wdata(wd[0]),
      .a_rdata(rdata[0]), .a_drive(drive[0]),
      .b_en_n(en_n[1]), .b_en(en[1]), .b_rd(rd[1]), .b_lane_n(ln_n[1]),
      .b_oe_n(oe_n[1]), .b_reg_out(rgo[1]), .b_addr(addr[1]), .b_wdata(wd[1]),
      .b_rdata(rdata[1]), .b_drive(drive[1])
   );

   logic [15:0] model [WORDS];
   int nvec = 0;
   int nerr = 0;
   bit done = 1'b0;

   function automatic logic [15:0] lanes(input logic [15:0] v, input logic [1:0] on);
      return {on[1] ? v[15:8] : 8'h00, on[0] ? v[7:0] : 8'h00};
   endfunction

   function automatic logic [15:0] merge(input logic [15:0] old, input logic [15:0] nw,
                                         input logic [1:0] sel_n);
      return {sel_n[1] ? old[15:8] : nw[15:8], sel_n[0] ? old[7:0] : nw[7:0]};
   endfunction

   task automatic chk(input string tag, input int p, input logic [1:0] ed,
                      input logic [15:0] edat);
      nvec++;
      if (drive[p] !== ed || rdata[p] !== edat) begin
         nerr++;
         $display("FAIL %s port%0d drive=%b exp %b data=%h exp %h",
                  tag, p, drive[p], ed, rdata[p], edat);
      end
   endtask

   task automatic req(input int p, input logic a_n, input logic a, input logic r,
                      input logic [1:0] sn, input int ad, input logic [15:0] d);
      en_n[p] = a_n; en[p] = a; rd[p] = r; ln_n[p] = sn;
      addr[p] = AW'(ad); wd[p] = d;
   endtask

   task automatic idle(input int p);
      req(p, 1'b1, 1'b0, 1'b1, 2'b11, 0, 16'h0000);
   endtask

   // single write; checks that the write cycle drives nothing (R4)
   task automatic wr(input int p, input int ad, input logic [1:0] sn, input logic [15:0] d);
      req(p, 1'b0, 1'b1, 1'b0, sn, ad, d);
      @(negedge clk);
      chk("R4 write drives nothing", p, 2'b00, 16'h0000);
      idle(p);
      model[ad] = merge(model[ad], d, sn);
   endtask

   task automatic rdc(input string tag, input int p, input int ad, input logic [1:0] sn);
      logic [1:0] on;
      on = ~sn;
      req(p, 1'b0, 1'b1, 1'b1, sn, ad, 16'h0000);
      @(negedge clk);
      if (!rgo[p]) begin
         chk(tag, p, on, lanes(model[ad], on));
         idle(p);
      end else begin
         chk({tag, " early"}, p, 2'b00, 16'h0000);
         idle(p);
         @(negedge clk);
         chk(tag, p, on, lanes(model[ad], on));
      end
   endtask

   initial begin
      for (int p = 0; p < 2; p++) begin
         idle(p); oe_n[p] = 1'b0; rgo[p] = 1'b0;
      end
      // R11: read requested during reset drives nothing
      req(0, 1'b0, 1'b1, 1'b1, 2'b00, 1, 16'h0);
      repeat (3) @(negedge clk);
      chk("R11 reset", 0, 2'b00, 16'h0000);
      chk("R11 reset", 1, 2'b00, 16'h0000);
      idle(0);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: fill from port A, sweep reads from port B with every lane pattern (R3, R5, R7)
      for (int i = 0; i < WORDS; i++) model[i] = 16'h0000;
      for (int i = 0; i < WORDS; i++) wr(0, i, 2'b00, 16'((i * 16'h0901) ^ 16'hA55A));
      for (int i = 0; i < WORDS; i++) rdc("R1 R5 R7 flow read", 1, i, 2'(i));

      // R4: lane-masked writes from port B, registered reads from A (R8)
      for (int i = 0; i < WORDS; i++) wr(1, i, 2'((i + 1) % 4), 16'((i * 16'h1307) ^ 16'h3C0F));
      rgo[0] = 1'b1;
      for (int i = 0; i < WORDS; i++) rdc("R4 R8 registered read", 0, i, 2'b00);
      rgo[1] = 1'b1;
      for (int i = 0; i < 8; i++) rdc("R8 lane flags delayed", 1, i, 2'(i));
      rgo[0] = 1'b0; rgo[1] = 1'b0;

      // R2: deselected writes and reads
      req(0, 1'b1, 1'b1, 1'b0, 2'b00, 5, 16'hFFFF);
      @(negedge clk);
      req(0, 1'b0, 1'b0, 1'b0, 2'b00, 6, 16'hFFFF);
      @(negedge clk);
      req(0, 1'b1, 1'b1, 1'b1, 2'b00, 5, 16'h0);
      @(negedge clk);
      chk("R2 deselected read", 0, 2'b00, 16'h0000);
      req(0, 1'b0, 1'b0, 1'b1, 2'b00, 5, 16'h0);
      @(negedge clk);
      chk("R2 deselected read", 0, 2'b00, 16'h0000);
      idle(0);
      rdc("R2 word kept", 0, 5, 2'b00);
      rdc("R2 word kept", 0, 6, 2'b00);

      // R3: selected write with no lane
      req(0, 1'b0, 1'b1, 1'b0, 2'b11, 7, 16'hDEAD);
      @(negedge clk);
      idle(0);
      rdc("R3 no-lane write ignored", 1, 7, 2'b00);

      // R6: output enable acts between edges
      req(0, 1'b0, 1'b1, 1'b1, 2'b00, 3, 16'h0);
      @(negedge clk);
      chk("R6 before", 0, 2'b11, model[3]);
      #1 oe_n[0] = 1'b1;
      #1 chk("R6 disabled", 0, 2'b00, 16'h0000);
      oe_n[0] = 1'b0;
      #1 chk("R6 re-enabled", 0, 2'b11, model[3]);
      idle(0);
      @(negedge clk);

      // R9: simultaneous writes to one word
      req(0, 1'b0, 1'b1, 1'b0, 2'b00, 10, 16'h1111);
      req(1, 1'b0, 1'b1, 1'b0, 2'b00, 10, 16'h2222);
      @(negedge clk);
      idle(0); idle(1);
      model[10] = 16'h1111;
      rdc("R9 full overlap A wins", 1, 10, 2'b00);
      req(0, 1'b0, 1'b1, 1'b0, 2'b01, 10, 16'hAB00);
      req(1, 1'b0, 1'b1, 1'b0, 2'b10, 10, 16'h00CD);
      @(negedge clk);
      idle(0); idle(1);
      model[10] = 16'hABCD;
      rdc("R9 disjoint lanes both land", 0, 10, 2'b00);
      req(0, 1'b0, 1'b1, 1'b0, 2'b10, 10, 16'h7733);
      req(1, 1'b0, 1'b1, 1'b0, 2'b00, 10, 16'h4455);
      @(negedge clk);
      idle(0); idle(1);
      model[10] = 16'h4433;
      rdc("R9 partial overlap", 1, 10, 2'b00);

      // R10: read colliding with write on the other port
      req(0, 1'b0, 1'b1, 1'b0, 2'b00, 20, 16'hBEEF);
      req(1, 1'b0, 1'b1, 1'b1, 2'b00, 20, 16'h0);
      @(negedge clk);
      chk("R10 old data on collision", 1, 2'b11, model[20]);
      idle(0);
      model[20] = 16'hBEEF;
      req(1, 1'b0, 1'b1, 1'b1, 2'b00, 20, 16'h0);
      @(negedge clk);
      chk("R10 new data next edge", 1, 2'b11, 16'hBEEF);
      idle(1);
      @(negedge clk);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         nerr++;
         $display("FAIL watchdog expired");
         $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
         $finish;
      end
   end

endmodule